// File: doc/BRIEF.md
# Parallel-Op Write-Back Merge Log

This block sits beside a register file in a core that runs a small extension operation alongside a main operation within one instruction. Both operations read the same register state from before the instruction. The extension operation cannot write the register file while the main operation is still using its inputs. Instead it posts up to four pending writes into the log. Each pending write names a slot, a register index and a value. Log writes arrive on a valid/ready stream. The stream applies back-pressure by dropping `log_ready` for as long as the block is walking its slots. A beat is taken on any rising clock edge where `log_valid` and `log_ready` are both high. Apart from that, the sender can hold a beat as long as it likes.

The main-operation sequencer uses two plain strobes. A clear strobe is issued after the main operation has read its inputs and before it writes. It zeroes every logged destination register. The main operation then writes its results. An apply strobe follows: each logged value is ORed into the register's current contents, and the log is emptied. When both operations target the same register, the result is therefore the bitwise OR of the two outputs, with neither operation given priority. The block reads the register file through an asynchronous read port and writes it through a single write port. The register file itself lives outside the block.

Top module: `wb_merge_log`

## Requirements
- R1: After reset the block is idle: `busy` is low, `log_ready` is high, `rf_we` is low, and all four slots are empty, so an apply strobe issued before any log write produces no register write.
- R2: A log beat taken when `log_valid` and `log_ready` are both high stores its register index and value in the slot selected by the 2-bit `log_slot` field (0 to 3) and marks that slot occupied.
- R3: A beat addressed to a slot that is already occupied replaces that slot's index and value.
- R4: A clear strobe walks the slots and writes zero (`rf_wdata` = 0) to the register of each occupied slot. The log contents are kept.
- R5: An apply strobe walks the slots in order 0, 1, 2, 3, one slot per cycle, starting in the cycle after the strobe. For each occupied slot it writes `rf_rdata | value` to that slot's register, with `rf_raddr` equal to `rf_waddr`.
- R6: A walk ends at the first empty slot it meets, and no slot after that hole is written. `busy` is high for N+1 cycles when N leading slots are occupied and N < 4, and for 4 cycles when all four are occupied.
- R7: When an apply walk ends, all four slots are empty, including any slots left beyond a hole.
- R8: When two slots name the same register, the later slot reads the value already merged by the earlier one, so the register ends as the OR of both values with its prior contents.
- R9: While `busy` is high, `log_ready` is low and neither strobe has any effect.
- R10: If the clear and apply strobes arrive in the same idle cycle, only the clear walk runs.
- R11: A log beat taken in the same cycle as a strobe is stored before the walk starts and takes part in it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| log_valid | input | 1 | Log beat valid |
| log_ready | output | 1 | Log beat accepted this cycle (high when idle) |
| log_slot | input | 2 | Slot the beat is written to |
| log_idx | input | 5 | Destination register index |
| log_data | input | 16 | Value to merge |
| clr_go | input | 1 | Clear-targets strobe |
| apply_go | input | 1 | Apply strobe |
| busy | output | 1 | A clear or apply walk is in progress |
| rf_raddr | output | 5 | Register file read address |
| rf_rdata | input | 16 | Register file read data (asynchronous) |
| rf_we | output | 1 | Register file write enable |
| rf_waddr | output | 5 | Register file write address |
| rf_wdata | output | 16 | Register file write data |

## Verification
Two events can land on the same edge: a log beat and a strobe. The other collision is the clear and apply strobes together. The bench provokes the first by driving a beat and a strobe in one idle cycle. It then requires the new entry's register to be zeroed or merged in that same walk. For the second, it raises both strobes at once and expects zeroing only, with the log left intact. A third group of cases targets attempts made during a walk. The bench raises both strobes and a beat in the middle of a walk. It then checks three things: the number of register writes, the length of the busy window, and the later behaviour of the log. Together these show that none of those attempts left a trace.

// File: rtl/wbl_pkg.sv
package wbl_pkg;

  // Which kind of walk the sequencer is performing.
  typedef enum logic [1:0] {
    WALK_IDLE  = 2'd0,
    WALK_CLEAR = 2'd1,
    WALK_APPLY = 2'd2
  } walk_mode_e;

endpackage

// File: rtl/wbl_slot_table.sv
module wbl_slot_table #(
  parameter int SLOTS  = 4,
  parameter int IDX_W  = 5,
  parameter int DATA_W = 16,
  localparam int SLOT_W = $clog2(SLOTS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [SLOT_W-1:0] wr_slot,
  input  logic [IDX_W-1:0]  wr_idx,
  input  logic [DATA_W-1:0] wr_val,
  input  logic              drop_all,
  output logic [SLOTS-1:0]  slot_vld,
  output logic [IDX_W-1:0]  slot_idx [SLOTS],
  output logic [DATA_W-1:0] slot_val [SLOTS]
);

  for (genvar s = 0; s < SLOTS; s++) begin : g_slot
    logic hit;
    assign hit = wr_en && (wr_slot == SLOT_W'(s));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        slot_vld[s] <= 1'b0;
        slot_idx[s] <= '0;
        slot_val[s] <= '0;
      end else if (hit) begin
        slot_vld[s] <= 1'b1;
        slot_idx[s] <= wr_idx;
        slot_val[s] <= wr_val;
      end else if (drop_all) begin
        slot_vld[s] <= 1'b0;
      end
    end
  end

  // R2, R3
  slot_store_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> (slot_vld[$past(wr_slot)] && slot_idx[$past(wr_slot)] == $past(wr_idx)
               && slot_val[$past(wr_slot)] == $past(wr_val)));

endmodule

// File: rtl/wbl_sequencer.sv
module wbl_sequencer
  import wbl_pkg::*;
#(
  parameter int SLOTS = 4,
  localparam int SLOT_W = $clog2(SLOTS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr_go,
  input  logic              apply_go,
  input  logic [SLOTS-1:0]  slot_vld,
  output walk_mode_e        mode,
  output logic [SLOT_W-1:0] ptr,
  output logic              step_en,
  output logic              drop_all,
  output logic              busy
);

  localparam logic [SLOT_W-1:0] LAST = SLOT_W'(SLOTS - 1);

  walk_mode_e        mode_q;
  logic [SLOT_W-1:0] ptr_q;
  logic              done_now;

  assign busy     = (mode_q != WALK_IDLE);
  assign step_en  = busy && slot_vld[ptr_q];
  assign done_now = busy && (!slot_vld[ptr_q] || ptr_q == LAST);
  assign drop_all = done_now && (mode_q == WALK_APPLY);
  assign mode     = mode_q;
  assign ptr      = ptr_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q <= WALK_IDLE;
      ptr_q  <= '0;
    end else if (!busy) begin
      ptr_q <= '0;
      if (clr_go)        mode_q <= WALK_CLEAR;
      else if (apply_go) mode_q <= WALK_APPLY;
    end else if (done_now) begin
      mode_q <= WALK_IDLE;
      ptr_q  <= '0;
    end else begin
      ptr_q <= ptr_q + 1'b1;
    end
  end

  // Counts cycles already spent in the current walk.
  logic [SLOT_W:0] run_cnt;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     run_cnt <= '0;
    else if (!busy) run_cnt <= '0;
    else            run_cnt <= run_cnt + 1'b1;
  end

  // R6
  walk_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> (run_cnt < (SLOT_W+1)'(SLOTS)));

  // R5
  slot_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy)) |-> (ptr_q == SLOT_W'($past(ptr_q) + 1'b1)));

  // R9
  mode_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !done_now) |=> (mode_q == $past(mode_q)));

  // R10
  clear_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && clr_go && apply_go) |=> (mode_q == WALK_CLEAR));

endmodule

// File: rtl/wbl_merge_port.sv
module wbl_merge_port
  import wbl_pkg::*;
#(
  parameter int SLOTS  = 4,
  parameter int IDX_W  = 5,
  parameter int DATA_W = 16,
  localparam int SLOT_W = $clog2(SLOTS)
) (
  input  walk_mode_e        mode,
  input  logic [SLOT_W-1:0] ptr,
  input  logic              step_en,
  input  logic [IDX_W-1:0]  slot_idx [SLOTS],
  input  logic [DATA_W-1:0] slot_val [SLOTS],
  input  logic [DATA_W-1:0] rf_rdata,
  output logic [IDX_W-1:0]  rf_raddr,
  output logic              rf_we,
  output logic [IDX_W-1:0]  rf_waddr,
  output logic [DATA_W-1:0] rf_wdata
);

  logic [IDX_W-1:0]  cur_idx;
  logic [DATA_W-1:0] cur_val;

  assign cur_idx  = slot_idx[ptr];
  assign cur_val  = slot_val[ptr];
  assign rf_raddr = cur_idx;
  assign rf_waddr = cur_idx;
  assign rf_we    = step_en;

  always_comb begin
    unique case (mode)
      WALK_APPLY: rf_wdata = rf_rdata | cur_val;
      default:    rf_wdata = '0;
    endcase
  end

endmodule

// File: rtl/wb_merge_log.sv
module wb_merge_log
  import wbl_pkg::*;
#(
  parameter int SLOTS  = 4,
  parameter int IDX_W  = 5,
  parameter int DATA_W = 16,
  localparam int SLOT_W = $clog2(SLOTS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              log_valid,
  output logic              log_ready,
  input  logic [SLOT_W-1:0] log_slot,
  input  logic [IDX_W-1:0]  log_idx,
  input  logic [DATA_W-1:0] log_data,
  input  logic              clr_go,
  input  logic              apply_go,
  output logic              busy,
  output logic [IDX_W-1:0]  rf_raddr,
  input  logic [DATA_W-1:0] rf_rdata,
  output logic              rf_we,
  output logic [IDX_W-1:0]  rf_waddr,
  output logic [DATA_W-1:0] rf_wdata
);

  walk_mode_e        mode;
  logic [SLOT_W-1:0] ptr;
  logic              step_en;
  logic              drop_all;
  logic              wr_en;
  logic [SLOTS-1:0]  slot_vld;
  logic [IDX_W-1:0]  slot_idx [SLOTS];
  logic [DATA_W-1:0] slot_val [SLOTS];

  assign log_ready = !busy;
  assign wr_en     = log_valid && log_ready;

  wbl_slot_table #(.SLOTS(SLOTS), .IDX_W(IDX_W), .DATA_W(DATA_W)) i_table (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_en    (wr_en),
    .wr_slot  (log_slot),
    .wr_idx   (log_idx),
    .wr_val   (log_data),
    .drop_all (drop_all),
    .slot_vld (slot_vld),
    .slot_idx (slot_idx),
    .slot_val (slot_val)
  );

  wbl_sequencer #(.SLOTS(SLOTS)) i_seq (
    .clk      (clk),
    .rst_n    (rst_n),
    .clr_go   (clr_go),
    .apply_go (apply_go),
    .slot_vld (slot_vld),
    .mode     (mode),
    .ptr      (ptr),
    .step_en  (step_en),
    .drop_all (drop_all),
    .busy     (busy)
  );

  wbl_merge_port #(.SLOTS(SLOTS), .IDX_W(IDX_W), .DATA_W(DATA_W)) i_merge (
    .mode     (mode),
    .ptr      (ptr),
    .step_en  (step_en),
    .slot_idx (slot_idx),
    .slot_val (slot_val),
    .rf_rdata (rf_rdata),
    .rf_raddr (rf_raddr),
    .rf_we    (rf_we),
    .rf_waddr (rf_waddr),
    .rf_wdata (rf_wdata)
  );

  // R7
  log_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && $past(busy) && $past(mode == WALK_APPLY)) |-> (slot_vld == '0));

  // R9
  write_in_walk_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rf_we |-> busy);

  // R4
  clear_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rf_we && mode == WALK_CLEAR) |-> (rf_wdata == '0));

endmodule

// File: tb/test_wb_merge_log.sv
module test_wb_merge_log;
  localparam int CLK_PERIOD = 10;
  localparam int SLOTS = 4;
  localparam int NREG  = 32;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        log_valid = 1'b0;
  logic        log_ready;
  logic [1:0]  log_slot = '0;
  logic [4:0]  log_idx = '0;
  logic [15:0] log_data = '0;
  logic        clr_go = 1'b0;
  logic        apply_go = 1'b0;
  logic        busy;
  logic [4:0]  rf_raddr;
  logic [15:0] rf_rdata;
  logic        rf_we;
  logic [4:0]  rf_waddr;
  logic [15:0] rf_wdata;

  always #(CLK_PERIOD/2) clk = ~clk;

  wb_merge_log i_wb_merge_log (
    .clk(clk), .rst_n(rst_n),
    .log_valid(log_valid), .log_ready(log_ready), .log_slot(log_slot),
    .log_idx(log_idx), .log_data(log_data),
    .clr_go(clr_go), .apply_go(apply_go), .busy(busy),
    .rf_raddr(rf_raddr), .rf_rdata(rf_rdata),
    .rf_we(rf_we), .rf_waddr(rf_waddr), .rf_wdata(rf_wdata)
  );

  // Environment register file and write counter.
  logic [15:0] env_rf [NREG];
  int wr_cnt;
  assign rf_rdata = env_rf[rf_raddr];
  always @(posedge clk) begin
    if (rf_we) begin
      env_rf[rf_waddr] <= rf_wdata;
      wr_cnt <= wr_cnt + 1;
    end
  end

  // Reference model.
  logic [15:0] exp_rf [NREG];
  bit          m_v   [SLOTS];
  logic [4:0]  m_idx [SLOTS];
  logic [15:0] m_val [SLOTS];

  int n_checks = 0;
  int n_fail = 0;

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  function automatic int leading_valid();
    int n = 0;
    for (int k = 0; k < SLOTS; k++) begin
      if (!m_v[k]) break;
      n++;
    end
    return n;
  endfunction

  function automatic void model_clear();
    for (int k = 0; k < SLOTS; k++) begin
      if (!m_v[k]) break;
      exp_rf[m_idx[k]] = 16'h0;
    end
  endfunction

  function automatic void model_apply();
    for (int k = 0; k < SLOTS; k++) begin
      if (!m_v[k]) break;
      exp_rf[m_idx[k]] = exp_rf[m_idx[k]] | m_val[k];
    end
    for (int k = 0; k < SLOTS; k++) m_v[k] = 1'b0;
  endfunction

  task automatic compare_rf(input string req);
    int bad = -1;
    for (int r = 0; r < NREG; r++)
      if (env_rf[r] !== exp_rf[r] && bad < 0) bad = r;
    if (bad < 0) check(1'b1, req, 0, 0);
    else check(1'b0, req, env_rf[bad], exp_rf[bad]);
  endtask

  task automatic log_write(input int s, input int idx, input int v);
    @(negedge clk);
    log_valid = 1'b1; log_slot = 2'(s); log_idx = 5'(idx); log_data = 16'(v);
    if (log_ready) begin
      m_v[s] = 1'b1; m_idx[s] = 5'(idx); m_val[s] = 16'(v);
    end
    @(negedge clk);
    log_valid = 1'b0;
  endtask

  // Runs one strobe cycle and follows the walk to its end.
  task automatic run_op(input bit do_clr, input bit do_app, input bit add_w,
                        input int ws, input int wi, input int wv,
                        input bit poke, input string req);
    int lead, cyc, exp_cyc, cnt_done;
    @(negedge clk);
    wr_cnt = 0;
    clr_go = do_clr; apply_go = do_app;
    if (add_w) begin
      log_valid = 1'b1; log_slot = 2'(ws); log_idx = 5'(wi); log_data = 16'(wv);
      m_v[ws] = 1'b1; m_idx[ws] = 5'(wi); m_val[ws] = 16'(wv);
    end
    lead = leading_valid();
    @(negedge clk);
    clr_go = 1'b0; apply_go = 1'b0; log_valid = 1'b0;
    cyc = 0;
    while (busy === 1'b1 && cyc < 10) begin
      cyc++;
      // R9: back-pressure while walking
      check(log_ready === 1'b0, "R9", log_ready, 0);
      if (poke && cyc == 1) begin
        clr_go = 1'b1; apply_go = 1'b1; log_valid = 1'b1;
        log_slot = 2'd3; log_idx = 5'd31; log_data = 16'hFFFF;
      end
      @(negedge clk);
      clr_go = 1'b0; apply_go = 1'b0; log_valid = 1'b0;
    end
    if (do_clr) model_clear();
    else if (do_app) model_apply();
    if (do_clr || do_app) begin
      exp_cyc = (lead < SLOTS) ? lead + 1 : SLOTS;
      // R6: busy window length
      check(cyc == exp_cyc, "R6", cyc, exp_cyc);
      // R5 / R4: one write per leading slot
      check(wr_cnt == lead, req, wr_cnt, lead);
    end
    compare_rf(req);
    if (poke) begin
      cnt_done = wr_cnt;
      repeat (2) @(negedge clk);
      // R9: strobes and beat during the walk left no trace
      check(busy === 1'b0 && wr_cnt == cnt_done, "R9", wr_cnt, cnt_done);
    end
  endtask

  task automatic finish_run();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    void'($urandom(32'd2718));
    for (int r = 0; r < NREG; r++) begin
      env_rf[r] = 16'(r * 16'h0911 + 16'h0123);
      exp_rf[r] = env_rf[r];
    end
    for (int k = 0; k < SLOTS; k++) begin
      m_v[k] = 1'b0; m_idx[k] = '0; m_val[k] = '0;
    end
    wr_cnt = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1: reset state
    check(busy === 1'b0, "R1", busy, 0);
    check(log_ready === 1'b1, "R1", log_ready, 1);
    check(rf_we === 1'b0, "R1", rf_we, 0);
    run_op(1'b0, 1'b1, 1'b0, 0, 0, 0, 1'b0, "R1");

    // R2, R8: four slots, two naming the same register
    log_write(0, 5, 16'h0011);
    log_write(1, 9, 16'h0F00);
    log_write(2, 5, 16'h8000);
    log_write(3, 12, 16'h00A0);
    run_op(1'b1, 1'b0, 1'b0, 0, 0, 0, 1'b0, "R4");
    env_rf[5] = 16'h0202; exp_rf[5] = 16'h0202;  // main operation result
    run_op(1'b0, 1'b1, 1'b0, 0, 0, 0, 1'b0, "R8");
    check(env_rf[5] == 16'h8213, "R8", env_rf[5], 16'h8213);

    // R7: log empty after apply
    run_op(1'b0, 1'b1, 1'b0, 0, 0, 0, 1'b0, "R7");

    // R6: hole at slot 1 stops the walk; R7 drops slot 2 too
    log_write(0, 3, 16'h0001);
    log_write(2, 4, 16'h0002);
    run_op(1'b0, 1'b1, 1'b0, 0, 0, 0, 1'b0, "R6");
    log_write(0, 6, 16'h0004);
    run_op(1'b0, 1'b1, 1'b0, 0, 0, 0, 1'b0, "R7");

    // R3: overwrite an occupied slot
    log_write(0, 7, 16'h1111);
    log_write(0, 8, 16'h2222);
    run_op(1'b0, 1'b1, 1'b0, 0, 0, 0, 1'b0, "R3");
    check(env_rf[7] == exp_rf[7], "R3", env_rf[7], exp_rf[7]);

    // R10: both strobes together -> clear only, log kept
    log_write(0, 10, 16'h00F0);
    run_op(1'b1, 1'b1, 1'b0, 0, 0, 0, 1'b0, "R10");
    run_op(1'b0, 1'b1, 1'b0, 0, 0, 0, 1'b0, "R10");

    // R11: beat in the strobe cycle joins the walk
    log_write(0, 14, 16'h0300);
    run_op(1'b1, 1'b0, 1'b1, 1, 15, 16'h0C00, 1'b0, "R11");
    run_op(1'b0, 1'b1, 1'b1, 2, 16, 16'h5000, 1'b0, "R11");

    // R9: strobes and a beat while walking
    log_write(0, 17, 16'h0040);
    log_write(1, 18, 16'h0080);
    run_op(1'b0, 1'b1, 1'b0, 0, 0, 0, 1'b1, "R9");
    run_op(1'b0, 1'b1, 1'b0, 0, 0, 0, 1'b0, "R9");

    // Random mix
    for (int it = 0; it < 80; it++) begin
      int nw, op;
      nw = int'($urandom_range(0, 5));
      for (int w = 0; w < nw; w++)
        log_write(int'($urandom_range(0, 3)), int'($urandom_range(0, NREG-1)),
                  int'($urandom_range(0, 16'hFFFF)));
      op = int'($urandom_range(0, 3));
      run_op(op == 0 || op == 2, op >= 1, $urandom_range(0, 3) == 0,
             int'($urandom_range(0, 3)), int'($urandom_range(0, NREG-1)),
             int'($urandom_range(0, 16'hFFFF)), $urandom_range(0, 4) == 0,
             (op == 1 || op == 3) ? "R5" : "R4");
    end

    finish_run();
  end

endmodule